// File: doc/BRIEF.md
# SIMD Memory Request Coalescer

This block collects the per-lane addresses of one warp-wide load or store and turns them into a short list of aligned memory transaction descriptors. A warp has 16 lanes. They arrive as four beats of four lanes each over a valid/ready input handshake. Beat b fills lanes 4b to 4b+3. Each lane carries a byte address and an active bit. The block does not decide anything until all four beats are held. Once they are, it picks one main transaction of 32, 64, 128 or 256 bytes. Every active word that the main transaction does not cover gets its own 4-byte transaction.

Descriptors leave over a valid/ready output handshake in ascending address order. Each descriptor carries a base address, a size code and a last flag. The input side stays closed from the fourth accepted beat until the final descriptor of that warp has been taken, so one warp is handled at a time.

The control is a three-state machine:
- `ST_COLLECT`: `in_ready` is high and beats are accepted.
- `ST_DECIDE`: one cycle in which the window is chosen and the descriptors are counted.
- `ST_EMIT`: `out_valid` is high.

Its transitions are:
- T_WARP_FULL: `ST_COLLECT` to `ST_DECIDE`, when the fourth beat is accepted.
- T_EMPTY: `ST_DECIDE` to `ST_COLLECT`, when no lane is active.
- T_HAS_WORK: `ST_DECIDE` to `ST_EMIT`, when at least one lane is active.
- T_FINAL: `ST_EMIT` to `ST_COLLECT`, when the last descriptor is accepted.

Top module: `simd_coalescer`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is 0 from the cycle after the fourth accepted beat until the cycle after the last descriptor is accepted. No descriptor is offered while `in_ready` is 1.
- R3: Let the span be the highest active address minus the lowest. The main window size is the smallest of 32/64/128/256 bytes that is larger than the span, or 256 when the span is 256 or more. When all active lanes fit in one aligned window of that size, exactly one descriptor is produced.
- R4: `out_size` encodes 0 = 4 bytes, 1 = 32, 2 = 64, 3 = 128, 4 = 256. `out_base` is always a multiple of the encoded size.
- R5: The main window is one of two candidates: the aligned window holding the lowest active address, or the aligned window holding the highest. The candidate that covers more active lanes wins. On a tie, the lower window wins.
- R6: Every active lane outside the main window yields a size-0 descriptor with base = address with bits [1:0] cleared. Lanes that share a word share one descriptor.
- R7: Within a warp, descriptors come out in strictly ascending base order. The main window is placed by its base.
- R8: `out_last` is 1 on the final descriptor of a warp and 0 on every other descriptor.
- R9: A warp with no active lane produces no descriptor, and `in_ready` returns to 1 two cycles after the fourth beat.
- R10: While `out_valid` is 1 and `out_ready` is 0, the descriptor fields stay unchanged and `out_valid` stays 1.
- R11: The addresses of inactive lanes affect neither the window nor the descriptors.
- R12: When the active span is 256 bytes or more, the main size is 256 and the remaining words are split off as single-word descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A beat of four lanes is offered |
| in_ready | output | 1 | The block accepts a beat |
| in_addr | input | LANES_PER_BEAT*ADDR_W | Lane byte addresses; lane k of the beat occupies bits [k*ADDR_W +: ADDR_W] |
| in_active | input | LANES_PER_BEAT | Lane k takes part in the access when bit k is set |
| out_valid | output | 1 | A descriptor is offered |
| out_ready | input | 1 | The consumer takes the descriptor |
| out_base | output | ADDR_W | Aligned transaction base address |
| out_size | output | 3 | Size code, see R4 |
| out_last | output | 1 | Final descriptor of the warp |

## Verification
The hardest situation to reach is one where the window chosen from the highest address wins. That case forces single-word descriptors below the main window, so the main descriptor must be slotted into the middle of the ascending stream. Directed warps reach it by placing one lone lane just under an aligned boundary, with the rest of the warp packed above it. Other directed warps place lanes across a boundary with an equal lane count on each side, to exercise the tie rule. Randomised warps confined to a few hundred bytes, run under a stuttering `out_ready`, then mix the window choice, duplicate words and backpressure together.

// File: rtl/coalesce_pkg.sv
package coalesce_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_DECIDE,
        ST_EMIT
    } co_state_e;

    localparam logic [2:0] SZ_WORD = 3'd0;
    localparam logic [2:0] SZ_32   = 3'd1;
    localparam logic [2:0] SZ_64   = 3'd2;
    localparam logic [2:0] SZ_128  = 3'd3;
    localparam logic [2:0] SZ_256  = 3'd4;

    // log2 of the byte count that a size code stands for
    function automatic int unsigned size_log2(input logic [2:0] code);
        int unsigned r;
        if (code == SZ_WORD) r = 2;
        else                 r = int'(code) + 4;
        return r;
    endfunction

endpackage

// File: rtl/coalesce_collect.sv
module coalesce_collect #(
    parameter int ADDR_W = 32,
    parameter int LPB    = 4,
    parameter int BEATS  = 4,
    localparam int LANES = LPB * BEATS,
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic [LPB*ADDR_W-1:0]         beat_addr,
    input  logic [LPB-1:0]                beat_act,
    output logic [LANES-1:0][ADDR_W-1:0]  lane_addr,
    output logic [LANES-1:0]              lane_act,
    output logic                          beat_last
);

    logic [BW-1:0] beat_idx;

    assign beat_last = (beat_idx == BW'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_idx <= '0;
        end else if (accept) begin
            if (beat_last) beat_idx <= '0;
            else           beat_idx <= beat_idx + BW'(1);
        end
    end

    // each accepted beat lands in its own slice of lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_act <= '0;
        end else begin
            for (int b = 0; b < BEATS; b++) begin
                for (int k = 0; k < LPB; k++) begin
                    if (accept && beat_idx == BW'(b)) begin
                        lane_addr[b*LPB+k] <= beat_addr[k*ADDR_W +: ADDR_W];
                        lane_act[b*LPB+k]  <= beat_act[k];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/coalesce_span.sv
module coalesce_span
    import coalesce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 16,
    parameter int CW     = 5
) (
    input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0]             lane_act,
    output logic                         any_act,
    output logic [ADDR_W-1:0]            win_base,
    output logic [2:0]                   win_code,
    output logic [CW-1:0]                total
);

    logic [ADDR_W-1:0] lo, hi, span, mask, base_lo, base_hi;
    logic [CW-1:0]     cnt_lo, cnt_hi, extra;
    logic              outside_i, outside_j, seen;

    always_comb begin
        lo      = '1;
        hi      = '0;
        any_act = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_act[i]) begin
                any_act = 1'b1;
                if (lane_addr[i] < lo) lo = lane_addr[i];
                if (lane_addr[i] > hi) hi = lane_addr[i];
            end
        end
        span = hi - lo;

        // smallest window size larger than the span
        if (span < ADDR_W'(32))       win_code = SZ_32;
        else if (span < ADDR_W'(64))  win_code = SZ_64;
        else if (span < ADDR_W'(128)) win_code = SZ_128;
        else                          win_code = SZ_256;

        mask    = (ADDR_W'(1) << size_log2(win_code)) - ADDR_W'(1);
        base_lo = lo & ~mask;
        base_hi = hi & ~mask;

        // lane count covered by each of the two candidate windows
        cnt_lo = '0;
        cnt_hi = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_act[i] && ((lane_addr[i] & ~mask) == base_lo)) cnt_lo = cnt_lo + CW'(1);
            if (lane_act[i] && ((lane_addr[i] & ~mask) == base_hi)) cnt_hi = cnt_hi + CW'(1);
        end
        win_base = (cnt_lo >= cnt_hi) ? base_lo : base_hi;

        // distinct words outside the chosen window
        extra = '0;
        for (int i = 0; i < LANES; i++) begin
            outside_i = lane_act[i] && ((lane_addr[i] & ~mask) != win_base);
            seen      = 1'b0;
            for (int j = 0; j < i; j++) begin
                outside_j = lane_act[j] && ((lane_addr[j] & ~mask) != win_base);
                if (outside_j && (lane_addr[j][ADDR_W-1:2] == lane_addr[i][ADDR_W-1:2]))
                    seen = 1'b1;
            end
            if (outside_i && !seen) extra = extra + CW'(1);
        end
        total = any_act ? (extra + CW'(1)) : '0;
    end

endmodule

// File: rtl/coalesce_pick.sv
module coalesce_pick
    import coalesce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 16,
    localparam int WW    = ADDR_W - 2
) (
    input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0]             lane_act,
    input  logic [ADDR_W-1:0]            win_base,
    input  logic [2:0]                   win_code,
    input  logic [WW-1:0]                cursor,
    input  logic                         cursor_valid,
    output logic                         found,
    output logic [WW-1:0]                next_word
);

    logic [ADDR_W-1:0]         win_mask;
    logic [LANES-1:0][WW-1:0]  lane_word;
    logic [LANES-1:0]          cand;

    assign win_mask = (ADDR_W'(1) << size_log2(win_code)) - ADDR_W'(1);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_word[i] = lane_addr[i][ADDR_W-1:2];
        assign cand[i] = lane_act[i]
                      && ((lane_addr[i] & ~win_mask) != win_base)
                      && (!cursor_valid || lane_word[i] > cursor);
    end

    // lowest remaining word outside the window
    always_comb begin
        found     = 1'b0;
        next_word = '0;
        for (int i = 0; i < LANES; i++) begin
            if (cand[i] && (!found || lane_word[i] < next_word)) begin
                found     = 1'b1;
                next_word = lane_word[i];
            end
        end
    end

endmodule

// File: rtl/simd_coalescer.sv
module simd_coalescer
    import coalesce_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int LANES_PER_BEAT = 4,
    parameter int BEATS          = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [LANES_PER_BEAT*ADDR_W-1:0]   in_addr,
    input  logic [LANES_PER_BEAT-1:0]          in_active,
    output logic                               out_valid,
    input  logic                               out_ready,
    output logic [ADDR_W-1:0]                  out_base,
    output logic [2:0]                         out_size,
    output logic                               out_last
);

    localparam int LANES = LANES_PER_BEAT * BEATS;
    localparam int CW    = $clog2(LANES + 2);
    localparam int WW    = ADDR_W - 2;

    co_state_e state_q, state_d;

    logic [LANES-1:0][ADDR_W-1:0] lane_addr;
    logic [LANES-1:0]             lane_act;
    logic                         beat_last;
    logic                         accept;
    logic                         fire;

    logic                         sp_any;
    logic [ADDR_W-1:0]            sp_base;
    logic [2:0]                   sp_code;
    logic [CW-1:0]                sp_total;

    logic [ADDR_W-1:0]            win_base_q;
    logic [2:0]                   win_code_q;
    logic [CW-1:0]                total_q;
    logic [CW-1:0]                sent_q;
    logic                         main_sent_q;
    logic [WW-1:0]                cursor_q;
    logic                         cur_valid_q;

    logic                         pk_found;
    logic [WW-1:0]                pk_word;
    logic [ADDR_W-1:0]            win_mask;
    logic [WW-1:0]                win_word;
    logic [WW-1:0]                win_end_word;
    logic                         take_main;
    logic                         is_last;

    assign accept = in_valid && in_ready;
    assign fire   = out_valid && out_ready;

    coalesce_collect #(
        .ADDR_W (ADDR_W),
        .LPB    (LANES_PER_BEAT),
        .BEATS  (BEATS)
    ) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .beat_addr (in_addr),
        .beat_act  (in_active),
        .lane_addr (lane_addr),
        .lane_act  (lane_act),
        .beat_last (beat_last)
    );

    coalesce_span #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .CW     (CW)
    ) u_span (
        .lane_addr (lane_addr),
        .lane_act  (lane_act),
        .any_act   (sp_any),
        .win_base  (sp_base),
        .win_code  (sp_code),
        .total     (sp_total)
    );

    coalesce_pick #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_pick (
        .lane_addr    (lane_addr),
        .lane_act     (lane_act),
        .win_base     (win_base_q),
        .win_code     (win_code_q),
        .cursor       (cursor_q),
        .cursor_valid (cur_valid_q),
        .found        (pk_found),
        .next_word    (pk_word)
    );

    // which descriptor is next: the main window or a lone word
    always_comb begin
        win_mask     = (ADDR_W'(1) << size_log2(win_code_q)) - ADDR_W'(1);
        win_word     = win_base_q[ADDR_W-1:2];
        win_end_word = win_base_q[ADDR_W-1:2] | win_mask[ADDR_W-1:2];
        take_main    = !main_sent_q && (!pk_found || win_word < pk_word);
        is_last      = (sent_q == total_q - CW'(1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (accept && beat_last) state_d = ST_DECIDE;   // T_WARP_FULL
            ST_DECIDE:  state_d = sp_any ? ST_EMIT : ST_COLLECT;        // T_HAS_WORK / T_EMPTY
            ST_EMIT:    if (fire && is_last) state_d = ST_COLLECT;      // T_FINAL
            default:    state_d = ST_COLLECT;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_COLLECT: in_ready  = 1'b1;
            ST_DECIDE:  in_ready  = 1'b0;
            ST_EMIT:    out_valid = 1'b1;
            default:    in_ready  = 1'b0;
        endcase
        out_base = take_main ? win_base_q : {pk_word, 2'b00};
        out_size = take_main ? win_code_q : SZ_WORD;
        out_last = is_last;
    end

    // per-warp emission bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_base_q  <= '0;
            win_code_q  <= SZ_32;
            total_q     <= '0;
            sent_q      <= '0;
            main_sent_q <= 1'b0;
            cursor_q    <= '0;
            cur_valid_q <= 1'b0;
        end else if (state_q == ST_DECIDE) begin
            win_base_q  <= sp_base;
            win_code_q  <= sp_code;
            total_q     <= sp_total;
            sent_q      <= '0;
            main_sent_q <= 1'b0;
            cur_valid_q <= 1'b0;
        end else if (state_q == ST_EMIT && fire) begin
            sent_q      <= sent_q + CW'(1);
            cur_valid_q <= 1'b1;
            if (take_main) begin
                main_sent_q <= 1'b1;
                cursor_q    <= win_end_word;
            end else begin
                cursor_q    <= pk_word;
            end
        end
    end

endmodule

// File: rtl/simd_coalescer_checker.sv
module coalesce_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_base,
    input logic [2:0]        out_size,
    input logic              out_last
);

    logic [ADDR_W-1:0] prev_base;
    logic              in_warp;
    logic [ADDR_W-1:0] align_mask;

    always_comb begin
        if (out_size == 3'd0) align_mask = ADDR_W'(3);
        else                  align_mask = (ADDR_W'(1) << (int'(out_size) + 4)) - ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_base <= '0;
            in_warp   <= 1'b0;
        end else if (out_valid && out_ready) begin
            prev_base <= out_base;
            in_warp   <= !out_last;
        end
    end

    p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    p_final_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> in_ready);

    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((out_base & align_mask) == '0) && out_size <= 3'd4));

    p_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_warp) |-> (out_base > prev_base));

    p_more_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_base)
                                       && $stable(out_size) && $stable(out_last)));

endmodule

bind simd_coalescer coalesce_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_base  (out_base),
    .out_size  (out_size),
    .out_last  (out_last)
);

// File: tb/simd_coalescer_tb.sv
module simd_coalescer_tb;

    typedef struct packed {
        logic [31:0] base;
        logic [2:0]  size;
        logic        last;
    } desc_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_addr = '0;
    logic [3:0]   in_active = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_base;
    logic [2:0]   out_size;
    logic         out_last;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    int bp_mode = 0;

    desc_t       exp_q[$];
    logic [31:0] stim_addr[16];
    logic        stim_act[16];

    always #2 clk = ~clk;   // 250 MHz

    simd_coalescer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_addr   (in_addr),
        .in_active (in_active),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_base  (out_base),
        .out_size  (out_size),
        .out_last  (out_last)
    );

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model written from the requirements
    task automatic predict();
        logic [31:0] lo, hi, span, mask, ba, bb, win;
        logic [2:0]  code;
        int          cnt_a, cnt_b;
        bit          any, dup, main_done;
        logic [29:0] w[$];
        logic [29:0] t;
        logic [31:0] bl[$];
        logic [2:0]  sl[$];
        lo = '1; hi = '0; any = 0;
        for (int i = 0; i < 16; i++) if (stim_act[i]) begin
            any = 1;
            if (stim_addr[i] < lo) lo = stim_addr[i];
            if (stim_addr[i] > hi) hi = stim_addr[i];
        end
        if (!any) return;                                  // R9
        span = hi - lo;
        if (span < 32) code = 1; else if (span < 64) code = 2;
        else if (span < 128) code = 3; else code = 4;     // R3 R12
        mask = (32'd1 << (int'(code) + 4)) - 1;
        ba = lo & ~mask; bb = hi & ~mask;
        cnt_a = 0; cnt_b = 0;
        for (int i = 0; i < 16; i++) if (stim_act[i]) begin
            if ((stim_addr[i] & ~mask) == ba) cnt_a++;
            if ((stim_addr[i] & ~mask) == bb) cnt_b++;
        end
        win = (cnt_a >= cnt_b) ? ba : bb;                  // R5
        for (int i = 0; i < 16; i++)
            if (stim_act[i] && (stim_addr[i] & ~mask) != win) begin
                dup = 0;
                foreach (w[k]) if (w[k] == stim_addr[i][31:2]) dup = 1;
                if (!dup) w.push_back(stim_addr[i][31:2]);  // R6
            end
        for (int a = 0; a < w.size(); a++)
            for (int b = 0; b + 1 < w.size() - a; b++)
                if (w[b] > w[b+1]) begin t = w[b]; w[b] = w[b+1]; w[b+1] = t; end
        main_done = 0;
        foreach (w[k]) begin                               // R7
            if (!main_done && win[31:2] < w[k]) begin
                bl.push_back(win); sl.push_back(code); main_done = 1;
            end
            bl.push_back({w[k], 2'b00}); sl.push_back(3'd0);
        end
        if (!main_done) begin bl.push_back(win); sl.push_back(code); end
        foreach (bl[k]) exp_q.push_back('{base: bl[k], size: sl[k], last: (k == bl.size() - 1)});
    endtask

    task automatic send_beat(input int b);
        @(negedge clk);
        in_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            in_addr[k*32 +: 32] = stim_addr[b*4+k];
            in_active[k]        = stim_act[b*4+k];
        end
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic run_warp(input string tag);
        bit any = 0;
        for (int i = 0; i < 16; i++) if (stim_act[i]) any = 1;
        predict();
        for (int b = 0; b < 4; b++) send_beat(b);
        @(negedge clk);
        in_valid = 1'b0;
        check(!in_ready, "R2", {tag, " in_ready after fourth beat"}, 32'(in_ready), 0);
        if (!any) begin
            @(negedge clk);
            check(in_ready && !out_valid, "R9", {tag, " empty warp returns"},
                  {30'd0, in_ready, out_valid}, 32'h2);
        end
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
    endtask

    task automatic fill(input logic [31:0] start, input int stride, input logic [15:0] act);
        for (int i = 0; i < 16; i++) begin
            stim_addr[i] = start + 32'(i * stride);
            stim_act[i]  = act[i];
        end
    endtask

    // scoreboard monitor
    bit          held = 0;
    logic [31:0] held_base;
    logic [2:0]  held_size;
    logic        held_last;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (held) begin
                check(out_valid && out_base == held_base && out_size == held_size
                      && out_last == held_last, "R10", "held descriptor", out_base, held_base);
            end
            out_ready = (bp_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
            if (out_valid && in_ready) check(0, "R2", "in_ready during emit", 1, 0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unexpected descriptor", out_base, 0);
                end else begin
                    desc_t e;
                    e = exp_q.pop_front();
                    check(out_base == e.base, "R7", "base", out_base, e.base);
                    check(out_size == e.size, "R4", "size", 32'(out_size), 32'(e.size));
                    check(out_last == e.last, "R8", "last", 32'(out_last), 32'(e.last));
                end
            end
            held = out_valid && !out_ready;
            held_base = out_base; held_size = out_size; held_last = out_last;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid, "R1", "reset state",
              {30'd0, in_ready, out_valid}, 32'h2);

        // R3: sixteen consecutive bytes -> one 32-byte transaction
        fill(32'hFFF0, 1, 16'hFFFF); run_warp("R3 bytes"); wait_idle();
        // R3: sixteen aligned words -> one 64-byte transaction
        fill(32'h1000, 4, 16'hFFFF); run_warp("R3 words"); wait_idle();
        // R6: boundary crossing -> 64 main plus seven single words
        fill(32'h101C, 4, 16'hFFFF); run_warp("R6 cross"); wait_idle();
        // R9: no active lane
        fill(32'h2000, 4, 16'h0000); run_warp("R9 empty"); wait_idle();
        // R6: every lane on the same word
        fill(32'h2004, 0, 16'hFFFF); run_warp("R6 dup"); wait_idle();
        // R5 R7: upper window wins, lone word emitted ahead of it
        fill(32'h3FC, 4, 16'hFFFF); stim_addr[0] = 32'h3F0;
        for (int i = 1; i < 16; i++) stim_addr[i] = 32'h400 + 32'((i - 1) * 4);
        run_warp("R5 upper"); wait_idle();
        // R5: tie between the two windows keeps the lower one
        fill(32'h5000, 4, 16'hFFFF);
        for (int i = 0; i < 8; i++) stim_addr[i] = 32'h5020 + 32'(i * 4);
        for (int i = 8; i < 16; i++) stim_addr[i] = 32'h5040 + 32'((i - 8) * 4);
        run_warp("R5 tie"); wait_idle();
        // R11: inactive lanes point far away
        fill(32'h6000, 4, 16'h00FF);
        for (int i = 8; i < 16; i++) stim_addr[i] = 32'hABCD_0000 + 32'(i * 512);
        run_warp("R11 inactive"); wait_idle();
        // R12: scattered lanes beyond 256 bytes
        fill(32'h8000, 100, 16'hFFFF); run_warp("R12 wide"); wait_idle();
        // R12: single active lane
        fill(32'h9000, 4, 16'h0400); run_warp("R12 single"); wait_idle();

        // R10 R7: random warps under stuttering backpressure
        bp_mode = 1;
        for (int n = 0; n < 60; n++) begin
            logic [31:0] region;
            region = 32'h0001_0000 + 32'(($urandom % 64) * 256);
            for (int i = 0; i < 16; i++) begin
                stim_addr[i] = region + 32'($urandom % (((n % 3) == 0) ? 64 : 600));
                stim_act[i]  = (($urandom % 4) != 0);
            end
            run_warp("R7 random");
            if (n % 5 == 0) wait_idle();
        end
        wait_idle();
        bp_mode = 0;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && in_ready && !out_valid, "R8", "drained at end",
              32'(exp_q.size()), 0);
        report();
    end

endmodule